// File: doc/BRIEF.md
# Round Key Generator with 80-bit Rotating Key Register

This block holds an 80-bit cipher key in one register and produces one 64-bit round key for a 64-bit block cipher datapath each time it is stepped. A load strobe writes a fresh key and resets an internal 5-bit round index to zero. Each step does four things to the register. It rotates the register left by 13 bit positions. It replaces the lowest nibble with its image through the cipher's 4-bit substitution box. It XORs the current round index into the 5-bit field at bits 63..59. It then advances the index.

The round key is the low 64 bits of the register. It comes straight from a flop, so it is stable for the whole cycle in which the datapath uses it. To obtain round keys 0 through 25, the cipher core loads the key and then issues one step before it needs each key. The step comes first, so key 0 is already the result of one update.

Top module: `rkey_rot80`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `rkey_o` reads all zeros and the round index is 0.
- R2: One cycle after `load_i` is high, `rkey_o` equals bits 63..0 of the `key_i` value that was presented, and the next step uses round index 0.
- R3: A step (`step_i` high, `load_i` low) rotates the whole 80-bit register left by 13, so bit j of the new register comes from bit (j-13) mod 80 of the old one, except for the fields named in R4 and R5.
- R4: After the rotation of a step, bits 3..0 are replaced by S(bits 3..0). The substitution, from input 0 to input F, gives E,4,B,1,7,9,C,A,D,2,0,F,8,5,3,6.
- R5: After the rotation of a step, bits 63..59 are XORed with the round index in use for that step.
- R6: The round key is bits 63..0 of the register after the update. It appears on `rkey_o` one clock after the step and holds until the next load or step.
- R7: The round index counts 0, 1, 2, and so on, one per step. It wraps from 31 to 0.
- R8: When `load_i` and `step_i` are high in the same cycle, the load takes effect and the step is discarded.
- R9: In a cycle where neither strobe is high, the register and the round index keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write `key_i` into the key register and clear the round index |
| key_i | input | 80 | Cipher key |
| step_i | input | 1 | Apply one schedule update |
| rkey_o | output | 64 | Current round key (register bits 63..0) |

## Verification
Every result of this block is due exactly one clock after the strobe that causes it: a load shows its key on `rkey_o` after one edge, and so does a step. The bench changes its inputs on the falling edge, lets exactly one rising edge pass, and then compares `rkey_o` at the next falling edge against a bench model that it advanced in step with that edge. Held cycles are checked the same way, so a value that changes late or early counts as a mismatch in that cycle. Directed cases pin known values for the rotation, the substitution and the index field. Random sequences of loads and steps, together with a run of more than 32 steps, cover index wrap and the case where a load and a step arrive in the same cycle.

// File: rtl/rkey_rot80.sv
module rkey_rot80 #(
  parameter int KEY_W   = 80,
  parameter int RK_W    = 64,
  parameter int ROT     = 13,
  parameter int IDX_W   = 5,
  parameter int IDX_LSB = 59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             step_i,
  output logic [RK_W-1:0]  rkey_o
);
  localparam int NIB     = 4;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [KEY_W-1:0] key_q, rot_w, nxt_w;
  logic [IDX_W-1:0] idx_q;

  function automatic logic [NIB-1:0] sub4(input logic [NIB-1:0] x);
    case (x)
      4'h0: sub4 = 4'hE;  4'h1: sub4 = 4'h4;  4'h2: sub4 = 4'hB;  4'h3: sub4 = 4'h1;
      4'h4: sub4 = 4'h7;  4'h5: sub4 = 4'h9;  4'h6: sub4 = 4'hC;  4'h7: sub4 = 4'hA;
      4'h8: sub4 = 4'hD;  4'h9: sub4 = 4'h2;  4'hA: sub4 = 4'h0;  4'hB: sub4 = 4'hF;
      4'hC: sub4 = 4'h8;  4'hD: sub4 = 4'h5;  4'hE: sub4 = 4'h3;  default: sub4 = 4'h6;
    endcase
  endfunction

  assign rot_w = {key_q[KEY_W-ROT-1:0], key_q[KEY_W-1:KEY_W-ROT]};

  always_comb begin
    nxt_w                  = rot_w;
    nxt_w[NIB-1:0]         = sub4(rot_w[NIB-1:0]);
    nxt_w[IDX_MSB:IDX_LSB] = rot_w[IDX_MSB:IDX_LSB] ^ idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      key_q <= key_i;
      idx_q <= '0;
    end else if (step_i) begin
      key_q <= nxt_w;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign rkey_o = key_q[RK_W-1:0];

  // load writes the key and clears the index (R2); load wins over step (R8)
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (key_q == $past(key_i)) && (idx_q == '0));

  // untouched bits follow a 13-bit left rotation (R3)
  assert_rot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=>
      (key_q[IDX_LSB-1:ROT] == $past(key_q[IDX_LSB-1-ROT:0])) &&
      (key_q[KEY_W-1:IDX_MSB+1] == $past(key_q[KEY_W-1-ROT:IDX_MSB+1-ROT])) &&
      (key_q[ROT-1:NIB] == $past(key_q[KEY_W-1:KEY_W-ROT+NIB])));

  // lowest nibble passes through the substitution (R4)
  assert_sbox_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=>
      key_q[NIB-1:0] == sub4($past(key_q[KEY_W-ROT+NIB-1:KEY_W-ROT])));

  // index field gets the round index XORed in (R5)
  assert_idx_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=>
      key_q[IDX_MSB:IDX_LSB] == ($past(key_q[IDX_MSB-ROT:IDX_LSB-ROT]) ^ $past(idx_q)));

  // index advances by one per step, wrapping naturally (R7)
  assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> idx_q == $past(idx_q) + 1'b1);

  // idle cycles hold state (R9)
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(key_q) && $stable(idx_q));
endmodule

// File: tb/test_rkey_rot80.sv
module test_rkey_rot80;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [79:0] key_i = '0;
  logic        step_i = 1'b0;
  logic [63:0] rkey_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [79:0] m_key;
  logic [4:0]  m_idx;

  always #2.5 clk = ~clk;

  rkey_rot80 i_rkey_rot80 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
    .step_i(step_i), .rkey_o(rkey_o)
  );

  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [63:0] tbl;
    tbl = 64'h6358_F02D_AC97_1B4E;
    return tbl[x*4 +: 4];
  endfunction

  function automatic logic [79:0] model_upd(input logic [79:0] k, input logic [4:0] i);
    logic [79:0] r;
    r = (k << 13) | (k >> 67);
    r[3:0]   = sb(r[3:0]);
    r[63:59] = r[63:59] ^ i;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; drives, passes one rising edge, checks at the next falling edge
  task automatic cyc(input bit ld, input logic [79:0] k, input bit st, input string req);
    load_i = ld; key_i = k; step_i = st;
    @(posedge clk);
    if (ld) begin m_key = k; m_idx = 5'd0; end
    else if (st) begin m_key = model_upd(m_key, m_idx); m_idx = m_idx + 5'd1; end
    @(negedge clk);
    check(req, rkey_o, m_key[63:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_key = '0; m_idx = '0;
    @(negedge clk);
    check("R1", rkey_o, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rkey_o, 64'h0);

    // all-zero key: first step gives S(0)=E, index 0 (R4)
    cyc(1, 80'h0, 0, "R2");
    cyc(0, 80'h0, 1, "R6");
    check("R4", rkey_o, 64'h0000_0000_0000_000E);
    cyc(0, 80'h0, 1, "R6");
    check("R5", rkey_o, 64'h0800_0000_0001_C00E);

    // single top bit rotates into bit 12 (R3)
    cyc(1, 80'h8000_0000_0000_0000_0000, 0, "R2");
    cyc(0, 80'h0, 1, "R3");
    check("R3", rkey_o, 64'h0000_0000_0000_100E);

    // full schedule of 26 round keys
    cyc(1, {$urandom, $urandom, $urandom}, 0, "R2");
    for (int n = 0; n < 26; n++) cyc(0, 80'h0, 1, "R6");

    // idle hold (R9)
    for (int n = 0; n < 4; n++) cyc(0, {$urandom, $urandom, $urandom}, 0, "R9");

    // load with a step in the same cycle (R8), then steps confirm index reset
    cyc(0, 80'h0, 1, "R6");
    cyc(1, {$urandom, $urandom, $urandom}, 1, "R8");
    cyc(0, 80'h0, 1, "R8");

    // index wraps past 31 (R7)
    cyc(1, 80'h0123_4567_89AB_CDEF_FEDC, 0, "R2");
    for (int n = 0; n < 40; n++) cyc(0, 80'h0, 1, "R7");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] r;
      r = 3'($urandom);
      cyc(r == 0, {$urandom, $urandom, $urandom}, r[1] | r[2], "R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule